// File: doc/BRIEF.md
# Cascadable LCD Segment Line Latch

This block gathers one display line of segment bits from a narrow parallel bus and presents, for each segment output, a 2-bit code that selects one of four drive levels. A data strobe writes one nibble or one byte per edge into a fill latch, using an internal position counter. A load strobe copies the completed fill latch into a line latch that feeds the outputs. The copy happens all at once, so a new line can be gathered while the previous one is still being shown.

Several copies of the block can be chained to drive a wide panel. Each copy starts gathering data when its active-low enable input is low. Once it holds a full line, it pulls its enable output low, and that output is the next copy's enable input. A direction input sets the order in which segment positions are filled. It also decides which of the two chain pins acts as the input and which as the output. Each chain pin is modelled as an input, an output value and an output-enable. The data and load strobes are plain levels sampled by the system clock. The block acts on their high-to-low transitions.

Top module: `seg_line_latch`

## Requirements
- R1: With `bus_wide`=1 and `dir_sel`=0, the j-th accepted byte b (j counting from 0) goes to segments 8j+k, which get b[7-k] for k = 0..7.
- R2: With `bus_wide`=1 and `dir_sel`=1, the j-th accepted byte b goes to segments 8(G-1-j)+k, which get b[k], where G = SEGS/8.
- R3: With `bus_wide`=0, only `bus_data[3:0]` is used. The j-th nibble n goes to segments 4j+k with n[3-k] when `dir_sel`=0, and to segments 4(2G-1-j)+k with n[k] when `dir_sel`=1. A full line takes 2G strobes.
- R4: The segment codes change only on the clock edge that sees `load_stb` fall. At that edge the line latch takes the whole fill latch.
- R5: A `data_stb` fall is ignored while the selected enable input is high. The selected enable input is `chain_a_i` when `dir_sel`=0 and `chain_b_i` when `dir_sel`=1.
- R6: The enable output is `chain_b` when `dir_sel`=0 and `chain_a` when `dir_sel`=1. Its `_oe` is 1 and the other pin's `_oe` is 0. The enable output goes low on the edge that accepts the last unit of a line, and it stays low until a load. An unused output value is 1.
- R7: Once a line is full, further `data_stb` falls change nothing until the next load.
- R8: A `load_stb` fall sets the enable output back to high and resets the fill position to the start of the line.
- R9: The code for each segment comes from `alt_m` and the latched bit d. It is 00 when alt_m=1 and d=1, 01 when alt_m=1 and d=0, 10 when alt_m=0 and d=0, and 11 when alt_m=0 and d=1. Segment i uses bits [2i+1:2i] of `seg_level`.
- R10: While `blank_n` is low, every segment code is 11, whatever the data and `alt_m`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_stb | input | 1 | Data strobe level; a fall captures one unit |
| load_stb | input | 1 | Load strobe level; a fall moves the line to the outputs |
| bus_data | input | 8 | Parallel segment data |
| bus_wide | input | 1 | 1: byte bus, 0: nibble bus on bits 3..0 |
| dir_sel | input | 1 | Fill order and chain-pin roles |
| alt_m | input | 1 | Drive alternation |
| blank_n | input | 1 | Low forces all segments to code 11 |
| chain_a_i | input | 1 | Chain pin A, sensed value |
| chain_b_i | input | 1 | Chain pin B, sensed value |
| chain_a_o | output | 1 | Chain pin A, driven value |
| chain_a_oe | output | 1 | Chain pin A, output enable |
| chain_b_o | output | 1 | Chain pin B, driven value |
| chain_b_oe | output | 1 | Chain pin B, output enable |
| seg_level | output | 2*SEGS | Two-bit level code per segment |

## Verification
The hardest state to reach from the ports is a full fill latch that then gets stray strobes: extra data edges after the last unit, or a load that arrives in the middle of a line. Those edges must leave no trace. Each scenario fills a whole line with a computed pattern, sends one more strobe with different data, and only then loads. Any leak of that extra strobe shows up in the segment codes. A separate scenario loads after a partial line and then refills. This shows whether the position counter really restarted.

// File: rtl/seg_latch_pkg.sv
package seg_latch_pkg;

  typedef enum logic [1:0] {
    LVL_SEL_HI   = 2'b00,
    LVL_UNSEL_HI = 2'b01,
    LVL_UNSEL_LO = 2'b10,
    LVL_SEL_LO   = 2'b11
  } drive_lvl_e;

  // Drive level from blanking, alternation and the latched segment bit.
  function automatic drive_lvl_e pick_level(input logic blank_n, input logic alt,
                                            input logic bit_on);
    if (!blank_n) return LVL_SEL_LO;
    case ({alt, bit_on})
      2'b11:   return LVL_SEL_HI;
      2'b10:   return LVL_UNSEL_HI;
      2'b00:   return LVL_UNSEL_LO;
      default: return LVL_SEL_LO;
    endcase
  endfunction

  // Target of segment seg for capture unit unit_no: {hit, value}.
  function automatic logic [1:0] place_bit(input int seg, input int unit_no,
                                           input int segs, input logic wide,
                                           input logic dir, input logic [7:0] d);
    int w;
    int p;
    int k;
    w = wide ? 8 : 4;
    p = dir ? (segs / w) - 1 - unit_no : unit_no;
    k = seg - p * w;
    if (k < 0 || k >= w) return 2'b00;
    return {1'b1, dir ? d[k] : d[w - 1 - k]};
  endfunction

endpackage

// File: rtl/strobe_fall.sv
module strobe_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign fall = prev_q & ~strobe;
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl #(
  parameter int NIB_SLOTS = 40
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cp_fall,
  input  logic                              load_fall,
  input  logic                              wide,
  input  logic                              en_in_n,
  output logic [$clog2(NIB_SLOTS+2)-1:0]    idx,
  output logic                              cap_fire,
  output logic                              full
);
  localparam int IW = $clog2(NIB_SLOTS + 2);

  logic [IW-1:0] step;
  logic [IW-1:0] next_idx;

  assign step     = wide ? IW'(2) : IW'(1);
  assign next_idx = idx + step;
  assign cap_fire = cp_fall & ~load_fall & ~en_in_n & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (load_fall) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (cap_fire) begin
      if (next_idx >= IW'(NIB_SLOTS)) begin
        idx  <= '0;
        full <= 1'b1;
      end else begin
        idx  <= next_idx;
      end
    end
  end
endmodule

// File: rtl/seg_line_store.sv
module seg_line_store
  import seg_latch_pkg::*;
#(
  parameter int SEGS = 160,
  parameter int IW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_fire,
  input  logic            load_fall,
  input  logic [IW-1:0]   idx,
  input  logic            wide,
  input  logic            dir,
  input  logic [7:0]      data,
  output logic [SEGS-1:0] fill_q,
  output logic [SEGS-1:0] line_q
);
  logic [SEGS-1:0] wr_mask;
  logic [SEGS-1:0] wr_val;
  int              unit_no;

  assign unit_no = wide ? int'(idx >> 1) : int'(idx);

  always_comb begin
    for (int i = 0; i < SEGS; i++) begin
      logic [1:0] hv;
      hv         = place_bit(i, unit_no, SEGS, wide, dir, data);
      wr_mask[i] = hv[1] & cap_fire;
      wr_val[i]  = hv[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      line_q <= '0;
    end else begin
      fill_q <= (fill_q & ~wr_mask) | (wr_val & wr_mask);
      if (load_fall) line_q <= fill_q;
    end
  end
endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
  import seg_latch_pkg::*;
#(
  parameter int SEGS = 160
) (
  input  logic [SEGS-1:0]   line_q,
  input  logic              alt_m,
  input  logic              blank_n,
  output logic [2*SEGS-1:0] seg_level
);
  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    assign seg_level[2*g +: 2] = pick_level(blank_n, alt_m, line_q[g]);
  end
endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
  parameter int SEGS = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_stb,
  input  logic              load_stb,
  input  logic [7:0]        bus_data,
  input  logic              bus_wide,
  input  logic              dir_sel,
  input  logic              alt_m,
  input  logic              blank_n,
  input  logic              chain_a_i,
  input  logic              chain_b_i,
  output logic              chain_a_o,
  output logic              chain_a_oe,
  output logic              chain_b_o,
  output logic              chain_b_oe,
  output logic [2*SEGS-1:0] seg_level
);
  localparam int NIB_SLOTS = SEGS / 4;
  localparam int IW        = $clog2(NIB_SLOTS + 2);

  // Named internal events, also used by the bound checker.
  logic            cp_fall;
  logic            load_fall;
  logic            cap_fire;
  logic            full;
  logic            en_in_n;
  logic            en_out_n;
  logic [IW-1:0]   idx;
  logic [SEGS-1:0] fill_q;
  logic [SEGS-1:0] line_q;

  strobe_fall u_cp_edge   (.clk(clk), .rst_n(rst_n), .strobe(data_stb), .fall(cp_fall));
  strobe_fall u_load_edge (.clk(clk), .rst_n(rst_n), .strobe(load_stb), .fall(load_fall));

  assign en_in_n  = dir_sel ? chain_b_i : chain_a_i;
  assign en_out_n = ~full;

  assign chain_a_oe = dir_sel;
  assign chain_b_oe = ~dir_sel;
  assign chain_a_o  = dir_sel ? en_out_n : 1'b1;
  assign chain_b_o  = dir_sel ? 1'b1 : en_out_n;

  seg_fill_ctrl #(.NIB_SLOTS(NIB_SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cp_fall(cp_fall), .load_fall(load_fall),
    .wide(bus_wide), .en_in_n(en_in_n), .idx(idx), .cap_fire(cap_fire), .full(full)
  );

  seg_line_store #(.SEGS(SEGS), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .load_fall(load_fall),
    .idx(idx), .wide(bus_wide), .dir(dir_sel), .data(bus_data),
    .fill_q(fill_q), .line_q(line_q)
  );

  seg_level_enc #(.SEGS(SEGS)) u_enc (
    .line_q(line_q), .alt_m(alt_m), .blank_n(blank_n), .seg_level(seg_level)
  );
endmodule

// File: rtl/seg_line_latch_chk.sv
module seg_line_latch_chk #(
  parameter int SEGS = 160,
  parameter int IW   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_fall,
  input logic              cap_fire,
  input logic              full,
  input logic              en_out_n,
  input logic              blank_n,
  input logic [IW-1:0]     idx,
  input logic [SEGS-1:0]   fill_q,
  input logic [SEGS-1:0]   line_q,
  input logic [2*SEGS-1:0] seg_level
);
  // R8
  load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> (en_out_n && idx == '0));

  // R7
  full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !load_fall) |=> ($stable(fill_q) && full));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fall |=> $stable(line_q));

  // R10
  blank_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (&seg_level));

  // R6
  handoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_out_n) |-> $past(cap_fire));
endmodule

bind seg_line_latch seg_line_latch_chk #(.SEGS(SEGS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_fall(load_fall), .cap_fire(cap_fire),
  .full(full), .en_out_n(en_out_n), .blank_n(blank_n), .idx(idx),
  .fill_q(fill_q), .line_q(line_q), .seg_level(seg_level)
);

// File: tb/test_seg_line_latch.sv
module test_seg_line_latch;
  localparam int SEGS = 160;
  localparam int G    = SEGS / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              data_stb = 1'b0, load_stb = 1'b0;
  logic [7:0]        bus_data = '0;
  logic              bus_wide = 1'b1, dir_sel = 1'b0, alt_m = 1'b1, blank_n = 1'b1;
  logic              chain_a_i = 1'b1, chain_b_i = 1'b1;
  logic              chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
  logic [2*SEGS-1:0] seg_level;

  int checks = 0;
  int errors = 0;
  logic [SEGS-1:0] exp_line = '0;

  always #5 clk = ~clk;

  seg_line_latch #(.SEGS(SEGS)) i_seg_line_latch (
    .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .load_stb(load_stb),
    .bus_data(bus_data), .bus_wide(bus_wide), .dir_sel(dir_sel), .alt_m(alt_m),
    .blank_n(blank_n), .chain_a_i(chain_a_i), .chain_b_i(chain_b_i),
    .chain_a_o(chain_a_o), .chain_a_oe(chain_a_oe), .chain_b_o(chain_b_o),
    .chain_b_oe(chain_b_oe), .seg_level(seg_level)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int want_code(input logic d);
    if (!blank_n) return 3;
    if (alt_m) return d ? 0 : 1;
    return d ? 3 : 2;
  endfunction

  // Compare every segment code against exp_line; one check per call.
  task automatic check_line(input string req, input string what);
    int bad;
    int a0;
    int e0;
    bad = -1; a0 = 0; e0 = 0;
    for (int i = SEGS - 1; i >= 0; i--) begin
      if (int'(seg_level[2*i +: 2]) != want_code(exp_line[i])) begin
        bad = i; a0 = int'(seg_level[2*i +: 2]); e0 = want_code(exp_line[i]);
      end
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s %s: segment %0d actual=%0d expected=%0d", req, what, bad, a0, e0);
    end
  endtask

  task automatic strobe_unit(input logic [7:0] d);
    @(negedge clk); bus_data = d; data_stb = 1'b1;
    @(negedge clk); data_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_load();
    @(negedge clk); load_stb = 1'b1;
    @(negedge clk); load_stb = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int j, input int seed);
    return 8'((j * 37 + seed * 11 + 5) & 255);
  endfunction

  // Expected placement written from R1, R2, R3.
  task automatic model_unit(input int j, input logic [7:0] d);
    if (bus_wide) begin
      for (int k = 0; k < 8; k++)
        if (!dir_sel) exp_line[8*j + k] = d[7-k];
        else          exp_line[8*(G-1-j) + k] = d[k];
    end else begin
      for (int k = 0; k < 4; k++)
        if (!dir_sel) exp_line[4*j + k] = d[3-k];
        else          exp_line[4*(2*G-1-j) + k] = d[k];
    end
  endtask

  task automatic set_enable(input logic v);
    if (!dir_sel) begin chain_a_i = v; chain_b_i = 1'b1; end
    else          begin chain_b_i = v; chain_a_i = 1'b1; end
  endtask

  function automatic int enable_out();
    return dir_sel ? int'(chain_a_o) : int'(chain_b_o);
  endfunction

  task automatic t_reset();
    check("R9", "reset code seg0", int'(seg_level[1:0]), 1);
    check_line("R9", "reset line all zero");
    check("R6", "reset A output idle", int'(chain_a_o), 1);
    check("R6", "reset B output idle", int'(chain_b_o), 1);
    check("R6", "dir0 B is output", int'(chain_b_oe), 1);
    check("R6", "dir0 A not output", int'(chain_a_oe), 0);
  endtask

  // Full line fill, then an extra strobe, then load.
  task automatic t_fill(input string req, input logic wide, input logic dir, input int seed);
    logic [SEGS-1:0] shown;
    int units;
    shown = exp_line;
    @(negedge clk); bus_wide = wide; dir_sel = dir; set_enable(1'b0);
    units = wide ? G : 2 * G;
    for (int j = 0; j < units; j++) begin
      logic [7:0] d;
      d = pat(j, seed);
      if (!wide) d = {~d[3:0], d[3:0]};
      strobe_unit(d);
      if (!wide) d = {4'h0, d[3:0]};
      model_unit(j, d);
      if (j == units - 2) check("R6", "enable out high before last unit", enable_out(), 1);
    end
    check("R6", "enable out low when full", enable_out(), 0);
    check("R6", "selected pin output enable", dir ? int'(chain_a_oe) : int'(chain_b_oe), 1);
    begin
      logic [SEGS-1:0] tmp;
      tmp = exp_line; exp_line = shown;
      check_line("R4", "outputs unchanged before load");
      exp_line = tmp;
    end
    strobe_unit(8'h5A);
    strobe_unit(8'hC3);
    strobe_load();
    check_line(req, "line after load");
    check_line("R7", "extra strobes after full ignored");
    check("R8", "enable out released by load", enable_out(), 1);
  endtask

  task automatic t_gate();
    @(negedge clk); bus_wide = 1'b1; dir_sel = 1'b0; set_enable(1'b1);
    for (int j = 0; j < 4; j++) strobe_unit(8'hFF);
    strobe_load();
    check_line("R5", "strobes ignored while enable input high");
    check("R5", "enable out stays high", enable_out(), 1);
  endtask

  task automatic t_restart();
    @(negedge clk); bus_wide = 1'b1; dir_sel = 1'b0; set_enable(1'b0);
    for (int j = 0; j < 5; j++) strobe_unit(8'h81);
    strobe_load();
    for (int j = 0; j < G; j++) begin
      strobe_unit(pat(j, 9));
      model_unit(j, pat(j, 9));
    end
    check("R8", "counter restart fills exactly G units", enable_out(), 0);
    strobe_load();
    check_line("R8", "refill after partial line starts at segment 0");
  endtask

  task automatic t_levels();
    @(negedge clk); alt_m = 1'b0;
    @(negedge clk);
    check_line("R9", "alternation low codes");
    blank_n = 1'b0;
    @(negedge clk);
    check_line("R10", "blank forces code 3 with alt low");
    alt_m = 1'b1;
    @(negedge clk);
    check_line("R10", "blank forces code 3 with alt high");
    blank_n = 1'b1;
    @(negedge clk);
    check_line("R9", "alternation high codes");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill("R1", 1'b1, 1'b0, 1);
    t_fill("R2", 1'b1, 1'b1, 2);
    t_fill("R3", 1'b0, 1'b0, 3);
    t_fill("R3", 1'b0, 1'b1, 4);
    t_gate();
    t_restart();
    t_levels();
    finish_run();
  end
endmodule